// File: doc/BRIEF.md
# Two-Phase Chopper Bridge Controller

This block holds the digital control for two full-bridge winding drivers that regulate current by peak chopping. Each bridge gets a direction bit, a 2-bit magnitude code and an overcurrent flag from an external comparator. From these the block drives four gate enables per bridge: a high side and a low side on each of the two legs. It also passes a 2-bit threshold select back to that bridge's comparator.

A shared oscillator tick switches bridge 0 on. An internal timer produces a second tick half an oscillator period later, and that tick switches bridge 1 on, so the two bridges do not switch on at the same moment.

When the comparator trips, only the low-side switch of the active diagonal opens. The current then recirculates through the high side, which gives slow decay. The low side stays open until that bridge's next turn-on tick.

A change of direction opens every switch of that bridge for a programmable dead time, which gives fast decay. Holding the active-low inhibit input low opens every switch of both bridges and puts the block in standby.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: The magnitude code of a bridge is copied to its threshold select at every turn-on tick. The code values are: 2'b11 for zero current, 2'b10 for one third of full scale, 2'b01 for two thirds and 2'b00 for full scale.
- R2: With direction 1 the active diagonal is leg-1 high side plus leg-2 low side (hs bit 2k, ls bit 2k+1). With direction 0 it is leg-2 high side plus leg-1 low side (hs bit 2k+1, ls bit 2k).
- R3: Bridge 0 switches on one clock after an oscillator tick is sampled. Bridge 1 switches on OSC_CYCLES/2 clocks after bridge 0.
- R4: An overcurrent flag passes through a 2-flop synchronizer. It opens the low side of the bridge 3 clocks after it is applied, and the high side stays closed.
- R5: Once the low side has opened on overcurrent, it stays open until the next turn-on tick of that bridge, even after the flag drops. That tick closes it again.
- R6: When inhibit is low, every gate enable is 0 from the next clock, and turn-on ticks have no effect.
- R7: After inhibit is released, the bridge stays off until its next turn-on tick. At that tick it switches on, with the threshold select taken from the code present at that moment.
- R8: A direction change opens all switches of that bridge from the next clock. Turn-on ticks are ignored for DEAD_CYC clocks.
- R9: A direction change that arrives during a running dead time restarts the dead time.
- R10: While the code is zero (2'b11), the bridge keeps all its switches open and a tick does not switch it on.
- R11: The high side and the low side of the same leg are never enabled together.
- R12: After reset all gate enables are 0 and every threshold select reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_n | input | 1 | Low: all switches open, standby |
| osc_tick | input | 1 | One-cycle chopper oscillator pulse |
| dir_in | input | 2 | Direction per bridge (bit k = bridge k) |
| mag_in | input | 4 | Magnitude code, bridge k at [2k+1:2k] |
| ocp_in | input | 2 | Asynchronous overcurrent flag per bridge |
| hs_en | output | 4 | High-side enables, bridge k leg1 at 2k, leg2 at 2k+1 |
| ls_en | output | 4 | Low-side enables, same bit layout |
| thr_sel | output | 4 | Threshold select to comparator, bridge k at [2k+1:2k] |

## Verification
The bench checks the following corner cases and the failure each one exposes:

- **Bridge 1 timing.** Bridge 1 is sampled one clock before and exactly at its delayed turn-on. A timer that is off by one, or missing, fails this check.
- **Overcurrent latching.** The overcurrent flag is dropped early. A sink that re-arms within the same cycle would close again, and a source that opens along with the sink would stop recirculation.
- **Dead time and restart.** A second direction flip is made inside a running dead time. A design that does not restart the dead time accepts the next tick too early.
- **Inhibit release.** The magnitude code is changed while inhibit is low. A design that resumes without waiting for a tick, or that keeps a stale threshold, shows the wrong enables or the wrong select.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int NPH = 2;
  typedef logic [1:0] mag_t;
  localparam mag_t MAG_ZERO = 2'b11;
endpackage

// File: rtl/chop_sync2.sv
module chop_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/chop_phase_tick.sv
module chop_phase_tick #(
  parameter int OSC_CYCLES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  output logic [1:0] turn_on
);
  localparam int HALF = (OSC_CYCLES / 2 > 0) ? OSC_CYCLES / 2 : 1;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          run_q, run_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          late_tick;

  assign late_tick = run_q && (cnt_q == CW'(HALF - 1));

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (osc_tick) begin
      run_n = 1'b1;
      cnt_n = '0;
    end else if (late_tick) begin
      run_n = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
    end
  end

  assign turn_on = {late_tick, osc_tick};

  // R3: the delayed tick ends its run; it cannot repeat on the next clock
  p_late_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (late_tick && !osc_tick) |=> !late_tick);
endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit_n,
  input  logic       turn_on,
  input  logic       dir_in,
  input  mag_t       mag_in,
  input  logic       ocp_in,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output mag_t       thr_sel
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic          dir_q, dir_n;
  logic [DW-1:0] dead_q, dead_n;
  logic          src_q, src_n;
  logic          snk_q, snk_n;
  mag_t          thr_q, thr_n;
  logic          trip_s;
  logic          dead_busy;
  logic          accept;

  chop_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(ocp_in), .q(trip_s));

  assign dead_busy = (dead_q != '0);
  assign accept    = turn_on && !dead_busy;

  always_comb begin
    dir_n  = dir_q;
    dead_n = dead_q;
    src_n  = src_q;
    snk_n  = snk_q;
    thr_n  = thr_q;
    if (dead_busy) dead_n = dead_q - 1'b1;
    if (dir_in != dir_q) begin
      dir_n  = dir_in;
      dead_n = DW'(DEAD_CYC);
      src_n  = 1'b0;
      snk_n  = 1'b0;
    end else if (!inhibit_n) begin
      src_n = 1'b0;
      snk_n = 1'b0;
    end else if (mag_in == MAG_ZERO) begin
      src_n = 1'b0;
      snk_n = 1'b0;
      if (accept) thr_n = mag_in;
    end else if (accept) begin
      src_n = 1'b1;
      snk_n = 1'b1;
      thr_n = mag_in;
    end else if (trip_s && snk_q) begin
      snk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dead_q <= '0;
      src_q  <= 1'b0;
      snk_q  <= 1'b0;
      thr_q  <= MAG_ZERO;
    end else begin
      dir_q  <= dir_n;
      dead_q <= dead_n;
      src_q  <= src_n;
      snk_q  <= snk_n;
      thr_q  <= thr_n;
    end
  end

  assign hs_en   = {src_q & ~dir_q, src_q & dir_q};
  assign ls_en   = {snk_q & dir_q, snk_q & ~dir_q};
  assign thr_sel = thr_q;

  // R6: standby opens everything on the next clock
  p_inhibit_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |=> (hs_en == 2'b00 && ls_en == 2'b00));

  // R10: zero code never leaves a switch closed
  p_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_in == MAG_ZERO) |=> (hs_en == 2'b00 && ls_en == 2'b00));

  // R8: direction change opens the bridge
  p_dir_flip_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in != dir_q) |=> (hs_en == 2'b00 && ls_en == 2'b00));

  // R4: a closed sink always has its source closed (slow decay path)
  p_sink_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en != 2'b00) |-> (hs_en != 2'b00));
endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int OSC_CYCLES = 512,
  parameter int DEAD_CYC   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit_n,
  input  logic       osc_tick,
  input  logic [1:0] dir_in,
  input  logic [3:0] mag_in,
  input  logic [1:0] ocp_in,
  output logic [3:0] hs_en,
  output logic [3:0] ls_en,
  output logic [3:0] thr_sel
);
  logic [NPH-1:0] turn_on;

  chop_phase_tick #(.OSC_CYCLES(OSC_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .turn_on(turn_on)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_br
    chop_bridge #(.DEAD_CYC(DEAD_CYC)) u_br (
      .clk(clk),
      .rst_n(rst_n),
      .inhibit_n(inhibit_n),
      .turn_on(turn_on[k]),
      .dir_in(dir_in[k]),
      .mag_in(mag_in[2*k+1:2*k]),
      .ocp_in(ocp_in[k]),
      .hs_en(hs_en[2*k+1:2*k]),
      .ls_en(ls_en[2*k+1:2*k]),
      .thr_sel(thr_sel[2*k+1:2*k])
    );
  end

  // R11: no leg ever has both its switches closed
  p_leg_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == 4'b0000);
endmodule

// File: tb/tb_chop_bridge_ctrl.sv
`timescale 1ns/1ps
module tb_chop_bridge_ctrl;
  localparam int OSC  = 40;
  localparam int HALF = OSC / 2;
  localparam int DEAD = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inhibit_n;
  logic       osc_tick;
  logic [1:0] dir_in;
  logic [3:0] mag_in;
  logic [1:0] ocp_in;
  logic [3:0] hs_en, ls_en, thr_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chop_bridge_ctrl #(.OSC_CYCLES(OSC), .DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .osc_tick(osc_tick),
    .dir_in(dir_in), .mag_in(mag_in), .ocp_in(ocp_in),
    .hs_en(hs_en), .ls_en(ls_en), .thr_sel(thr_sel)
  );

  // entry: [5]=dir1 [4]=dir0 [3:2]=mag1 [1:0]=mag0
  localparam logic [5:0] VEC [6] = '{
    6'b11_00_10, 6'b01_01_00, 6'b00_10_01,
    6'b10_11_00, 6'b11_00_11, 6'b01_10_10
  };

  function automatic logic [1:0] exp_hs(input logic d, input logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : (d ? 2'b01 : 2'b10);
  endfunction
  function automatic logic [1:0] exp_ls(input logic d, input logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : (d ? 2'b10 : 2'b01);
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inhibit_n = 1'b1; osc_tick = 1'b0;
    dir_in = 2'b00; mag_in = 4'b1111; ocp_in = 2'b00;
    step(3);
    chk("R12 hs", hs_en, 4'b0000);
    chk("R12 ls", ls_en, 4'b0000);
    chk("R12 thr", thr_sel, 4'b1111);
    rst_n = 1'b1;
    step(2);

    // table: R1, R2, R3, R10 under several patterns
    for (int i = 0; i < 6; i++) begin
      dir_in = VEC[i][5:4];
      mag_in = VEC[i][3:0];
      step(DEAD + 4);
      pulse_tick();
      chk("R2 hs b0", {2'b00, hs_en[1:0]}, {2'b00, exp_hs(VEC[i][4], VEC[i][1:0])});
      chk("R2 ls b0", {2'b00, ls_en[1:0]}, {2'b00, exp_ls(VEC[i][4], VEC[i][1:0])});
      chk("R1 thr b0", {2'b00, thr_sel[1:0]}, {2'b00, VEC[i][1:0]});
      step(HALF);
      chk("R3 hs b1", {2'b00, hs_en[3:2]}, {2'b00, exp_hs(VEC[i][5], VEC[i][3:2])});
      chk("R3 ls b1", {2'b00, ls_en[3:2]}, {2'b00, exp_ls(VEC[i][5], VEC[i][3:2])});
      chk("R1 thr b1", {2'b00, thr_sel[3:2]}, {2'b00, VEC[i][3:2]});
    end
    // now dir = 2'b01, both codes 2'b10, both bridges on

    // R3: exact offset of bridge 1
    mag_in = 4'b1111;
    step(2);
    chk("R10 off", hs_en | ls_en, 4'b0000);
    mag_in = 4'b0100;
    pulse_tick();
    chk("R3 b0 on", hs_en, 4'b0001);
    chk("R3 b1 not yet", hs_en[3:2] | ls_en[3:2], 2'b00);
    step(HALF - 1);
    chk("R3 b1 before half", {hs_en[3:2], ls_en[3:2]}, 4'b0000);
    step(1);
    chk("R3 b1 at half", {hs_en[3:2], ls_en[3:2]}, 4'b1001);

    // R4 / R5: trip on bridge 0
    ocp_in = 2'b01;
    step(2);
    chk("R4 sink before sync", ls_en, 4'b0110);
    step(1);
    chk("R4 sink open", ls_en, 4'b0100);
    chk("R4 source held", hs_en, 4'b1001);
    ocp_in = 2'b00;
    step(5);
    chk("R5 sink latched", ls_en, 4'b0100);
    pulse_tick();
    chk("R5 rearm at tick", ls_en, 4'b0110);

    // R6: inhibit
    inhibit_n = 1'b0;
    step(1);
    chk("R6 hs", hs_en, 4'b0000);
    chk("R6 ls", ls_en, 4'b0000);
    pulse_tick();
    step(HALF + 1);
    chk("R6 tick ignored", hs_en | ls_en, 4'b0000);

    // R7: release, new code picked at tick
    mag_in = 4'b0101;
    inhibit_n = 1'b1;
    step(3);
    chk("R7 waits for tick", hs_en | ls_en, 4'b0000);
    pulse_tick();
    chk("R7 b0 on", {hs_en[1:0], ls_en[1:0]}, 4'b0110);
    chk("R7 thr b0", {2'b00, thr_sel[1:0]}, 4'b0001);
    step(HALF);

    // R8: dead time on direction flip
    dir_in = 2'b00;
    step(1);
    chk("R8 off", {hs_en[1:0], ls_en[1:0]}, 4'b0000);
    step(30);
    pulse_tick();
    chk("R8 tick ignored", {hs_en[1:0], ls_en[1:0]}, 4'b0000);
    step(DEAD);
    pulse_tick();
    chk("R8 on after dead", {hs_en[1:0], ls_en[1:0]}, 4'b1001);

    // R9: second flip restarts dead time
    dir_in = 2'b01;
    step(40);
    dir_in = 2'b00;
    step(40);
    pulse_tick();
    chk("R9 restarted", {hs_en[1:0], ls_en[1:0]}, 4'b0000);
    step(30);
    pulse_tick();
    chk("R9 on after restart", {hs_en[1:0], ls_en[1:0]}, 4'b1001);

    // R10: zero code at a tick
    mag_in = 4'b0111;
    step(1);
    chk("R10 opened", {hs_en[1:0], ls_en[1:0]}, 4'b0000);
    pulse_tick();
    chk("R10 no chop", {hs_en[1:0], ls_en[1:0]}, 4'b0000);
    chk("R10 thr zero", {2'b00, thr_sel[1:0]}, 4'b0011);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule